// File: doc/BRIEF.md
# GPIO Bank Interrupt Detector

This block watches a bank of general-purpose input pins and turns programmed pin conditions into one interrupt line. Every pin passes through a two-stage synchronizer. A per-pin detector then compares the synchronized value with its value one cycle earlier, or looks at the level itself. Each pin has a 3-bit trigger code. When the condition that code selects is met, the detector sets a sticky status bit for that pin. The status bit stays set until software clears it.

Software uses a write port with a small operation code. It can enable pins by bank mask or one pin at a time, disable pins by mask, clear status bits by mask, and program one pin's trigger code. A read port shows the enable mask, the status word and the synchronized pin values. The interrupt output is a register. It holds the OR over all pins of status AND enable, so a disabled pin still records its events but does not raise the line.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset, every status bit is 0, every enable bit is 0, `irq_o` is 0, and every pin's trigger code is 0 (rising edge).
- R2: A change on a pin enters two synchronizer flops. A qualifying change driven before clock edge k makes the status bit visible after edge k+2 and not before. Read select 2 returns the synchronized pin values.
- R3: Trigger code 0 sets status only on a 0-to-1 transition of the synchronized pin.
- R4: Trigger code 1 sets status only on a 1-to-0 transition.
- R5: Trigger code 2 sets status on any transition and never while the pin is steady.
- R6: Trigger code 3 sets status while the pin is 1. A clear of a pin that is still high drops the bit for one cycle, and the bit is set again on the following edge.
- R7: Trigger code 4 sets status while the pin is 0.
- R8: Trigger codes 5, 6 and 7 never set status.
- R9: A status bit stays set until a write with operation 2 (status clear) carries a 1 in that bit position. Zero bits in the data leave their pins unchanged. Read select 1 returns the status word.
- R10: When a status clear and a new edge event on the same pin fall in the same cycle, the status bit stays set.
- R11: Operation 0 ORs the data into the enable mask. Operation 1 clears the enable bits where the data holds 1. Operation 4 enables the single pin whose index is in the low index bits of the data. Read select 0 returns the mask. A disabled pin's status never raises `irq_o`.
- R12: `irq_o` is registered. It equals the OR of status AND enable as it stood one cycle earlier.
- R13: Operation 3 writes a trigger code. The pin index is in data bits [IDX_W-1:0] and the code is in bits [IDX_W+2:IDX_W]. An index at or above the pin count is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pins_i | input | PINS | Asynchronous pin inputs |
| wr_en_i | input | 1 | Write strobe for one cycle |
| wr_op_i | input | 3 | Write operation code (0 enable set, 1 enable clear, 2 status clear, 3 trigger code, 4 single-pin enable) |
| wr_data_i | input | DW | Write data: a mask, or an index and code |
| rd_sel_i | input | 2 | Read select (0 enable, 1 status, 2 synchronized pins) |
| rd_data_o | output | PINS | Read data, combinational from the select |
| irq_o | output | 1 | Combined registered interrupt |

## Verification
The bench builds the block with PINS set to 4. This makes the index field two bits wide and the write data five bits wide. With that small bank, the bench can sweep every pin against all eight trigger codes and all four start and end pin-level pairs. The expected status word for each case is worked out from the code and the two levels. The small bank also makes it cheap to check that a reserved code or a masked pin disturbs nothing. The same configuration reaches the exact synchronizer latency, the one-cycle dip of a level-triggered bit after a clear, and the clear-versus-edge race on a single pin.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  // Trigger codes, 3 bits per pin; 5..7 are reserved.
  localparam logic [2:0] TRIG_RISE = 3'd0;
  localparam logic [2:0] TRIG_FALL = 3'd1;
  localparam logic [2:0] TRIG_BOTH = 3'd2;
  localparam logic [2:0] TRIG_HIGH = 3'd3;
  localparam logic [2:0] TRIG_LOW  = 3'd4;

  // Write operation codes.
  localparam logic [2:0] OP_EN_SET  = 3'd0;
  localparam logic [2:0] OP_EN_CLR  = 3'd1;
  localparam logic [2:0] OP_ST_CLR  = 3'd2;
  localparam logic [2:0] OP_TYPE    = 3'd3;
  localparam logic [2:0] OP_EN_PIN  = 3'd4;

  // Read selects.
  localparam logic [1:0] RD_ENABLE = 2'd0;
  localparam logic [1:0] RD_STATUS = 2'd1;
  localparam logic [1:0] RD_PINS   = 2'd2;
endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] chain_q;
  logic [STAGES-1:0][W-1:0] chain_d;

  always_comb begin
    chain_d[0] = d_i;
    for (int s = 1; s < STAGES; s++) chain_d[s] = chain_q[s-1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_irq_cfg.sv
module gpio_irq_cfg
  import gpio_irq_pkg::*;
#(
  parameter int PINS = 32,
  parameter int DW   = 32
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_en_i,
  input  logic [2:0]            wr_op_i,
  input  logic [DW-1:0]         wr_data_i,
  output logic [PINS-1:0]       en_o,
  output logic [PINS-1:0][2:0]  type_o,
  output logic [PINS-1:0]       clr_o
);
  localparam int IDX_W = $clog2(PINS);

  logic [PINS-1:0]      en_q, en_d;
  logic [PINS-1:0][2:0] type_q, type_d;
  logic [IDX_W-1:0]     idx;
  logic [2:0]           code;
  logic                 idx_ok;

  assign idx    = wr_data_i[IDX_W-1:0];
  assign code   = wr_data_i[IDX_W+2:IDX_W];
  assign idx_ok = ({1'b0, idx} < (IDX_W+1)'(PINS));

  always_comb begin
    en_d   = en_q;
    type_d = type_q;
    clr_o  = '0;
    if (wr_en_i) begin
      case (wr_op_i)
        OP_EN_SET: en_d  = en_q | wr_data_i[PINS-1:0];
        OP_EN_CLR: en_d  = en_q & ~wr_data_i[PINS-1:0];
        OP_ST_CLR: clr_o = wr_data_i[PINS-1:0];
        OP_TYPE:   if (idx_ok) type_d[idx] = code;
        OP_EN_PIN: if (idx_ok) en_d[idx] = 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= '0;
      type_q <= '0;
    end else if (wr_en_i) begin
      en_q   <= en_d;
      type_q <= type_d;
    end
  end

  assign en_o   = en_q;
  assign type_o = type_q;

  // R11: a disable write leaves no targeted pin enabled.
  assert_disable_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_op_i == OP_EN_CLR) |=> ((en_q & $past(wr_data_i[PINS-1:0])) == '0));
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
  import gpio_irq_pkg::*;
#(
  parameter int PINS = 32
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [PINS-1:0]       cur_i,
  input  logic [PINS-1:0][2:0]  type_i,
  input  logic [PINS-1:0]       clr_i,
  output logic [PINS-1:0]       status_o
);
  logic [PINS-1:0] prev_q;
  logic [PINS-1:0] hit;
  logic [PINS-1:0] status_q, status_d;

  for (genvar i = 0; i < PINS; i++) begin : g_pin
    always_comb begin
      case (type_i[i])
        TRIG_RISE: hit[i] =  cur_i[i] & ~prev_q[i];
        TRIG_FALL: hit[i] = ~cur_i[i] &  prev_q[i];
        TRIG_BOTH: hit[i] =  cur_i[i] ^  prev_q[i];
        TRIG_HIGH: hit[i] =  cur_i[i] & ~clr_i[i];
        TRIG_LOW:  hit[i] = ~cur_i[i] & ~clr_i[i];
        default:   hit[i] = 1'b0;
      endcase
    end

    assert_rise_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (type_i[i] == TRIG_RISE && cur_i[i] && !prev_q[i]) |=> status_q[i]);
    assert_fall_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (type_i[i] == TRIG_FALL && !cur_i[i] && prev_q[i]) |=> status_q[i]);
    assert_level_dip_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i[i] && type_i[i] == TRIG_HIGH) |=> !status_q[i]);
    assert_reserved_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (type_i[i] >= 3'd5 && !status_q[i]) |=> !status_q[i]);
    assert_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (status_q[i] && !clr_i[i]) |=> status_q[i]);
    assert_race_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i[i] && type_i[i] == TRIG_BOTH && (cur_i[i] != prev_q[i])) |=> status_q[i]);
  end

  always_comb status_d = (status_q & ~clr_i) | hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q   <= '0;
      status_q <= '0;
    end else begin
      prev_q   <= cur_i;
      status_q <= status_d;
    end
  end

  assign status_o = status_q;
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
  import gpio_irq_pkg::*;
#(
  parameter  int PINS  = 32,
  localparam int IDX_W = $clog2(PINS),
  localparam int DW    = (PINS > IDX_W + 3) ? PINS : IDX_W + 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [PINS-1:0] pins_i,
  input  logic            wr_en_i,
  input  logic [2:0]      wr_op_i,
  input  logic [DW-1:0]   wr_data_i,
  input  logic [1:0]      rd_sel_i,
  output logic [PINS-1:0] rd_data_o,
  output logic            irq_o
);
  logic [1:0]           rst_pipe_q;
  logic                 rst_n;
  logic [PINS-1:0]      pins_sync;
  logic [PINS-1:0]      en;
  logic [PINS-1:0][2:0] trig;
  logic [PINS-1:0]      clr;
  logic [PINS-1:0]      status;
  logic                 irq_d, irq_q;

  // Reset asserts at once and releases after two clocks.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_pipe_q <= '0;
    else         rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n = rst_pipe_q[1];

  gpio_irq_sync #(.W(PINS), .STAGES(2)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_n),
    .d_i   (pins_i),
    .q_o   (pins_sync)
  );

  gpio_irq_cfg #(.PINS(PINS), .DW(DW)) u_cfg (
    .clk_i    (clk_i),
    .rst_ni   (rst_n),
    .wr_en_i  (wr_en_i),
    .wr_op_i  (wr_op_i),
    .wr_data_i(wr_data_i),
    .en_o     (en),
    .type_o   (trig),
    .clr_o    (clr)
  );

  gpio_irq_detect #(.PINS(PINS)) u_detect (
    .clk_i   (clk_i),
    .rst_ni  (rst_n),
    .cur_i   (pins_sync),
    .type_i  (trig),
    .clr_i   (clr),
    .status_o(status)
  );

  always_comb irq_d = |(status & en);

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end
  assign irq_o = irq_q;

  always_comb begin
    case (rd_sel_i)
      RD_ENABLE: rd_data_o = en;
      RD_STATUS: rd_data_o = status;
      RD_PINS:   rd_data_o = pins_sync;
      default:   rd_data_o = '0;
    endcase
  end

  assert_mask_R11: assert property (@(posedge clk_i) disable iff (!rst_n)
    ((status & en) == '0) |=> !irq_o);
  assert_irq_reg_R12: assert property (@(posedge clk_i) disable iff (!rst_n)
    ((status & en) != '0) |=> irq_o);
endmodule

// File: tb/gpio_irq_bank_test.sv
`timescale 1ns/1ps
module gpio_irq_bank_test;
  import gpio_irq_pkg::*;

  localparam int PINS  = 4;
  localparam int IDX_W = 2;
  localparam int DW    = 5;

  logic            clk = 1'b0;
  logic            rst_ni;
  logic [PINS-1:0] pins;
  logic            wr_en;
  logic [2:0]      wr_op;
  logic [DW-1:0]   wr_data;
  logic [1:0]      rd_sel;
  logic [PINS-1:0] rd_data;
  logic            irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  gpio_irq_bank #(.PINS(PINS)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .pins_i(pins),
    .wr_en_i(wr_en), .wr_op_i(wr_op), .wr_data_i(wr_data),
    .rd_sel_i(rd_sel), .rd_data_o(rd_data), .irq_o(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] op, input logic [DW-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_op = op; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic rd(input logic [1:0] s, output logic [PINS-1:0] v);
    rd_sel = s;
    #0.5;
    v = rd_data;
  endtask

  task automatic set_type(input int p, input logic [2:0] c);
    wr(OP_TYPE, {c, IDX_W'(p)});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [PINS-1:0] v;
    string tag [8] = '{"R3", "R4", "R5", "R6", "R7", "R8", "R8", "R8"};
    rst_ni = 1'b0; pins = '0; wr_en = 1'b0; wr_op = '0; wr_data = '0; rd_sel = '0;
    cyc(3);
    rst_ni = 1'b1;
    cyc(4);

    // R1 reset state
    rd(RD_ENABLE, v); check("R1 enable", v, 0);
    rd(RD_STATUS, v); check("R1 status", v, 0);
    check("R1 irq", irq, 0);

    // R1 default rising code, R2 latency
    @(negedge clk); pins[0] = 1'b1;
    cyc(2); rd(RD_STATUS, v); check("R2 not before k+2", v, 0);
    cyc(1); rd(RD_STATUS, v); check("R1 R2 rise at k+2", v, 4'b0001);
    rd(RD_PINS, v); check("R2 pin readback", v, 4'b0001);

    for (int i = 0; i < PINS; i++) set_type(i, 3'd7);
    pins = '0; cyc(4);
    wr(OP_ST_CLR, '1);
    rd(RD_STATUS, v); check("R9 clear all", v, 0);

    // Sweep: every pin, every code, every level pair.
    for (int p = 0; p < PINS; p++)
      for (int c = 0; c < 8; c++)
        for (int l0 = 0; l0 < 2; l0++)
          for (int l1 = 0; l1 < 2; l1++) begin
            bit e;
            set_type(p, 3'd7);
            pins[p] = l0[0];
            cyc(4);
            wr(OP_ST_CLR, '1);
            set_type(p, c[2:0]);
            pins[p] = l1[0];
            cyc(4);
            case (c)
              0: e = (l0 == 0) && (l1 == 1);
              1: e = (l0 == 1) && (l1 == 0);
              2: e = (l0 != l1);
              3: e = (l0 == 1) || (l1 == 1);
              4: e = (l0 == 0) || (l1 == 0);
              default: e = 1'b0;
            endcase
            rd(RD_STATUS, v);
            check($sformatf("%s pin%0d code%0d %0d->%0d R13", tag[c], p, c, l0, l1),
                  v, {28'd0, 4'(e) << p});
            check("R11 masked irq", irq, 0);
          end

    set_type(p_idx(0), 3'd7);
    pins = '0; cyc(4); wr(OP_ST_CLR, '1);

    // R9 partial clear
    set_type(0, TRIG_RISE); set_type(1, TRIG_RISE);
    pins[1:0] = 2'b11; cyc(4);
    rd(RD_STATUS, v); check("R9 both set", v, 4'b0011);
    cyc(5); rd(RD_STATUS, v); check("R9 sticky", v, 4'b0011);
    wr(OP_ST_CLR, 5'b00001);
    rd(RD_STATUS, v); check("R9 partial clear", v, 4'b0010);
    wr(OP_ST_CLR, 5'b00010);
    rd(RD_STATUS, v); check("R9 second clear", v, 0);

    // R6 level dip and re-assert
    set_type(2, TRIG_HIGH);
    pins[2] = 1'b1; cyc(4);
    rd(RD_STATUS, v); check("R6 high set", v, 4'b0100);
    wr(OP_ST_CLR, 5'b00100);
    rd(RD_STATUS, v); check("R6 dip after clear", v, 0);
    cyc(1); rd(RD_STATUS, v); check("R6 reassert", v, 4'b0100);
    set_type(2, 3'd7); pins[2] = 1'b0; cyc(4); wr(OP_ST_CLR, '1);

    // R10 clear racing a new rising edge on pin 0
    pins[0] = 1'b0; cyc(4); wr(OP_ST_CLR, '1);
    rd(RD_STATUS, v); check("R10 precondition", v, 0);
    @(negedge clk); pins[0] = 1'b1;
    cyc(1);
    wr(OP_ST_CLR, 5'b00001);
    rd(RD_STATUS, v); check("R10 event wins", v, 4'b0001);
    wr(OP_ST_CLR, 5'b00001);
    rd(RD_STATUS, v); check("R10 plain clear", v, 0);

    // R11 / R12 enables and registered irq
    set_type(3, TRIG_RISE);
    pins[3] = 1'b1; cyc(4);
    rd(RD_STATUS, v); check("R11 masked status", v, 4'b1000);
    check("R11 masked irq", irq, 0);
    wr(OP_EN_PIN, {3'd0, 2'd3});
    check("R12 irq one cycle later", irq, 0);
    cyc(1); check("R12 irq set", irq, 1);
    rd(RD_ENABLE, v); check("R11 single enable", v, 4'b1000);
    wr(OP_EN_CLR, 5'b01000);
    rd(RD_ENABLE, v); check("R11 disable", v, 0);
    check("R12 irq held one cycle", irq, 1);
    cyc(1); check("R11 irq dropped", irq, 0);
    wr(OP_EN_SET, 5'b01001);
    rd(RD_ENABLE, v); check("R11 mask enable", v, 4'b1001);
    cyc(1); check("R12 irq from mask", irq, 1);
    wr(OP_ST_CLR, 5'b01000);
    cyc(1); check("R12 irq after clear", irq, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  function automatic int p_idx(input int p);
    return p;
  endfunction
endmodule